// File: doc/BRIEF.md
# Frame-Linear Video Timing Generator

This block produces horizontal sync, vertical sync and a display-enable strobe for a digital video output, one pixel per clock. Horizontal timing is counted by a line counter that restarts at the leading edge of each horizontal sync pulse. All vertical timing is counted by a single frame-wide counter that counts pixel clocks from the start of vertical sync. The vertical sync length and the vertical active window are therefore programmed as pixel counts rather than line counts.

Software programs the block through a one-cycle register write port. Every timing, colour and polarity value goes to a shadow set. That set is copied into the working set only when a frame starts, so a write in the middle of a frame never produces a mixed frame.

The block also drives the pixel path. Inside the active window it passes the input pixel. When the input stream underflows and recovery is enabled, it substitutes a programmed fill colour. Outside the window it drives a programmed border colour. Stopping the generator takes effect only at the end of the current frame.

Top module: `frame_linear_vtg`

## Requirements
- R1: After reset the generator is stopped. `hsync`, `vsync` and `disp_en` are low and `pix_out` is zero. They stay so until the enable bit (address 0, bit 0) is written to 1.
- R2: The line counter runs from 0 to line total minus 1, with 0 at the hsync leading edge. Horizontal sync is asserted for the first pulse-width pixels of every line. Address 1 holds the pulse width in bits [11:0] and the line total in bits [27:16].
- R3: Vertical sync is asserted for the first N pixel clocks of each frame, where N is held at address 3. A frame repeats every P pixel clocks, where P is held at address 2.
- R4: `disp_en` is high exactly when both of these hold, with all four bounds inclusive:
  - the line counter lies between the start and end columns (address 4, bits [11:0] and [27:16]);
  - the frame counter lies between the start (address 5) plus skew (address 9) and the end (address 6) plus skew.
- R5: Address 10 sets the sync polarity. Bit 0 makes hsync active-low and bit 1 makes vsync active-low. The working polarity also sets the level of both sync outputs while the generator is stopped.
- R6: While `disp_en` is high, `pix_out` carries `pix_in`. While running outside the window, it carries the border colour from address 7. While stopped, it is zero.
- R7: Address 8 holds the fill colour in bits [23:0] and a recovery bit in bit 31. Inside the window, when `pix_underflow` is high and recovery is set, `pix_out` is the fill colour. When recovery is clear, `pix_in` passes even during underflow.
- R8: Writing the enable bit while stopped loads the shadow set and starts a frame. `vsync` becomes active two clocks after the write is captured, because the counter and the output register each add one clock.
- R9: Clearing the enable bit while running lets the current frame complete. The outputs then go idle and stay idle.
- R10: Timing, colour and polarity writes made mid-frame or while stopped do not change any output until the next frame start or enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe, one cycle per write |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| pix_in | input | CW (24) | Pixel from the fetch path |
| pix_underflow | input | 1 | Fetch path has no valid pixel this clock |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| disp_en | output | 1 | Active-region strobe |
| pix_out | output | CW (24) | Pixel, border or fill colour |

## Verification
The assertions assume a consistent mode:
- the line total is at least 2;
- the frame period is a nonzero multiple of the line total;
- the sync lengths and the window bounds fit inside their periods.

Under those assumptions, the line counter wrap and the frame counter wrap coincide. The stimulus uses only two such hand-built modes, so it stays within these limits. All writes happen on falling edges, and the bench synchronises on the rising edge of vsync before it compares every pixel of a frame with a model built from the requirements.

// File: rtl/frame_linear_vtg_pkg.sv
package frame_linear_vtg_pkg;
   localparam int CFG_DW = 32;
   localparam int HI_LSB = 16;
   localparam int POL_H_BIT = 0;
   localparam int POL_V_BIT = 1;
   localparam int REC_BIT = 31;

   typedef enum logic [3:0] {
      RA_ENABLE = 4'd0,
      RA_HLINE  = 4'd1,
      RA_FRAME  = 4'd2,
      RA_VLEN   = 4'd3,
      RA_HWIN   = 4'd4,
      RA_VSTART = 4'd5,
      RA_VEND   = 4'd6,
      RA_BORDER = 4'd7,
      RA_UFLOW  = 4'd8,
      RA_SKEW   = 4'd9,
      RA_POL    = 4'd10
   } reg_addr_e;
endpackage

// File: rtl/frame_linear_vtg_regs.sv
module frame_linear_vtg_regs
   import frame_linear_vtg_pkg::*;
#(
   parameter int HW = 12,
   parameter int FW = 24,
   parameter int CW = 24,
   parameter bit SHADOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [3:0]        addr,
   input  logic [CFG_DW-1:0] wdata,
   input  logic              load,
   output logic              en_req,
   output logic [HW-1:0]     a_htot,
   output logic [HW-1:0]     a_hpw,
   output logic [HW-1:0]     a_hstart,
   output logic [HW-1:0]     a_hend,
   output logic [FW-1:0]     a_period,
   output logic [FW-1:0]     a_vlen,
   output logic [FW-1:0]     a_vstart,
   output logic [FW-1:0]     a_vend,
   output logic [FW-1:0]     a_skew,
   output logic [CW-1:0]     a_border,
   output logic [CW-1:0]     a_fill,
   output logic              a_rec,
   output logic              a_hpol,
   output logic              a_vpol
);
   localparam int SET_W = 4 * HW + 5 * FW + 2 * CW + 3;

   logic [HW-1:0] s_htot, s_hpw, s_hstart, s_hend;
   logic [FW-1:0] s_period, s_vlen, s_vstart, s_vend, s_skew;
   logic [CW-1:0] s_border, s_fill;
   logic          s_rec, s_hpol, s_vpol;
   logic [SET_W-1:0] shadow_set, active_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_req   <= 1'b0;
         s_htot   <= '0;
         s_hpw    <= '0;
         s_hstart <= '0;
         s_hend   <= '0;
         s_period <= '0;
         s_vlen   <= '0;
         s_vstart <= '0;
         s_vend   <= '0;
         s_skew   <= '0;
         s_border <= '0;
         s_fill   <= '0;
         s_rec    <= 1'b0;
         s_hpol   <= 1'b0;
         s_vpol   <= 1'b0;
      end else if (we) begin
         case (reg_addr_e'(addr))
            RA_ENABLE: en_req <= wdata[0];
            RA_HLINE: begin
               s_hpw  <= wdata[HW-1:0];
               s_htot <= wdata[HI_LSB+HW-1:HI_LSB];
            end
            RA_FRAME:  s_period <= wdata[FW-1:0];
            RA_VLEN:   s_vlen   <= wdata[FW-1:0];
            RA_HWIN: begin
               s_hstart <= wdata[HW-1:0];
               s_hend   <= wdata[HI_LSB+HW-1:HI_LSB];
            end
            RA_VSTART: s_vstart <= wdata[FW-1:0];
            RA_VEND:   s_vend   <= wdata[FW-1:0];
            RA_BORDER: s_border <= wdata[CW-1:0];
            RA_UFLOW: begin
               s_fill <= wdata[CW-1:0];
               s_rec  <= wdata[REC_BIT];
            end
            RA_SKEW:   s_skew <= wdata[FW-1:0];
            RA_POL: begin
               s_hpol <= wdata[POL_H_BIT];
               s_vpol <= wdata[POL_V_BIT];
            end
            default: ;
         endcase
      end
   end

   assign shadow_set = {s_htot, s_hpw, s_hstart, s_hend,
                        s_period, s_vlen, s_vstart, s_vend, s_skew,
                        s_border, s_fill, s_rec, s_hpol, s_vpol};

   generate
      if (SHADOW) begin : g_shadowed
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               active_set <= '0;
            else if (load)
               active_set <= shadow_set;
         end
      end else begin : g_direct
         assign active_set = shadow_set;
      end
   endgenerate

   assign {a_htot, a_hpw, a_hstart, a_hend,
           a_period, a_vlen, a_vstart, a_vend, a_skew,
           a_border, a_fill, a_rec, a_hpol, a_vpol} = active_set;
endmodule

// File: rtl/frame_linear_vtg_cnt.sv
module frame_linear_vtg_cnt #(
   parameter int HW = 12,
   parameter int FW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_req,
   input  logic [HW-1:0] htot,
   input  logic [FW-1:0] period,
   output logic          running,
   output logic [HW-1:0] hcnt,
   output logic [FW-1:0] fcnt,
   output logic          frame_end,
   output logic          load
);
   logic line_end;

   assign frame_end = running && (fcnt == period - 1'b1);
   assign line_end  = (hcnt == htot - 1'b1);
   assign load      = en_req && (!running || frame_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         hcnt    <= '0;
         fcnt    <= '0;
      end else if (!running || frame_end) begin
         hcnt    <= '0;
         fcnt    <= '0;
         running <= en_req;
      end else begin
         fcnt <= fcnt + 1'b1;
         hcnt <= line_end ? '0 : hcnt + 1'b1;
      end
   end
endmodule

// File: rtl/frame_linear_vtg_out.sv
module frame_linear_vtg_out #(
   parameter int HW = 12,
   parameter int FW = 24,
   parameter int CW = 24,
   parameter bit OUT_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          running,
   input  logic [HW-1:0] hcnt,
   input  logic [FW-1:0] fcnt,
   input  logic [HW-1:0] hpw,
   input  logic [HW-1:0] hstart,
   input  logic [HW-1:0] hend,
   input  logic [FW-1:0] vlen,
   input  logic [FW-1:0] vstart,
   input  logic [FW-1:0] vend,
   input  logic [FW-1:0] skew,
   input  logic          hpol,
   input  logic          vpol,
   input  logic [CW-1:0] border,
   input  logic [CW-1:0] fill,
   input  logic          rec,
   input  logic [CW-1:0] pix_in,
   input  logic          underflow,
   output logic          hsync,
   output logic          vsync,
   output logic          de,
   output logic [CW-1:0] pix_out
);
   logic [FW-1:0] v_lo, v_hi;
   logic          in_h, in_v;
   logic          hs_n, vs_n, de_n;
   logic [CW-1:0] pix_n, active_pix;

   assign v_lo = vstart + skew;
   assign v_hi = vend + skew;
   assign in_h = (hcnt >= hstart) && (hcnt <= hend);
   assign in_v = (fcnt >= v_lo) && (fcnt <= v_hi);

   assign hs_n = (running && (hcnt < hpw)) ^ hpol;
   assign vs_n = (running && (fcnt < vlen)) ^ vpol;
   assign de_n = running && in_h && in_v;

   assign active_pix = (underflow && rec) ? fill : pix_in;
   always_comb begin
      if (!running)
         pix_n = '0;
      else if (de_n)
         pix_n = active_pix;
      else
         pix_n = border;
   end

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hsync   <= 1'b0;
               vsync   <= 1'b0;
               de      <= 1'b0;
               pix_out <= '0;
            end else begin
               hsync   <= hs_n;
               vsync   <= vs_n;
               de      <= de_n;
               pix_out <= pix_n;
            end
         end
      end else begin : g_comb
         assign hsync   = hs_n;
         assign vsync   = vs_n;
         assign de      = de_n;
         assign pix_out = pix_n;
      end
   endgenerate
endmodule

// File: rtl/frame_linear_vtg.sv
module frame_linear_vtg
   import frame_linear_vtg_pkg::*;
#(
   parameter int HW = 12,
   parameter int FW = 24,
   parameter int CW = 24,
   parameter bit SHADOW = 1'b1,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [3:0]        cfg_addr,
   input  logic [CFG_DW-1:0] cfg_wdata,
   input  logic [CW-1:0]     pix_in,
   input  logic              pix_underflow,
   output logic              hsync,
   output logic              vsync,
   output logic              disp_en,
   output logic [CW-1:0]     pix_out
);
   generate
      if (HW < 2 || HW > CFG_DW - HI_LSB) begin : g_bad_hw
         $error("HW must lie in 2..16");
      end
      if (FW < HW || FW > CFG_DW) begin : g_bad_fw
         $error("FW must lie in HW..32");
      end
      if (CW < 1 || CW > REC_BIT) begin : g_bad_cw
         $error("CW must lie in 1..31");
      end
   endgenerate

   logic          en_req, load, running, frame_end;
   logic [HW-1:0] a_htot, a_hpw, a_hstart, a_hend, hcnt;
   logic [FW-1:0] a_period, a_vlen, a_vstart, a_vend, a_skew, fcnt;
   logic [CW-1:0] a_border, a_fill;
   logic          a_rec, a_hpol, a_vpol;

   frame_linear_vtg_regs #(.HW(HW), .FW(FW), .CW(CW), .SHADOW(SHADOW)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .load(load), .en_req(en_req),
      .a_htot(a_htot), .a_hpw(a_hpw), .a_hstart(a_hstart), .a_hend(a_hend),
      .a_period(a_period), .a_vlen(a_vlen), .a_vstart(a_vstart), .a_vend(a_vend),
      .a_skew(a_skew), .a_border(a_border), .a_fill(a_fill), .a_rec(a_rec),
      .a_hpol(a_hpol), .a_vpol(a_vpol)
   );

   frame_linear_vtg_cnt #(.HW(HW), .FW(FW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en_req(en_req), .htot(a_htot), .period(a_period),
      .running(running), .hcnt(hcnt), .fcnt(fcnt), .frame_end(frame_end),
      .load(load)
   );

   frame_linear_vtg_out #(.HW(HW), .FW(FW), .CW(CW), .OUT_REG(OUT_REG)) u_out (
      .clk(clk), .rst_n(rst_n), .running(running), .hcnt(hcnt), .fcnt(fcnt),
      .hpw(a_hpw), .hstart(a_hstart), .hend(a_hend), .vlen(a_vlen),
      .vstart(a_vstart), .vend(a_vend), .skew(a_skew), .hpol(a_hpol),
      .vpol(a_vpol), .border(a_border), .fill(a_fill), .rec(a_rec),
      .pix_in(pix_in), .underflow(pix_underflow),
      .hsync(hsync), .vsync(vsync), .de(disp_en), .pix_out(pix_out)
   );
endmodule

// File: rtl/frame_linear_vtg_chk.sv
module frame_linear_vtg_chk #(
   parameter int HW = 12,
   parameter int FW = 24,
   parameter bit SHADOW = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          running,
   input logic          en_req,
   input logic          frame_end,
   input logic [HW-1:0] hcnt,
   input logic [FW-1:0] fcnt,
   input logic [HW-1:0] htot,
   input logic [FW-1:0] period
);
   // R1
   stopped_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (hcnt == '0) && (fcnt == '0));

   // R8
   start_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> (fcnt == '0) && $past(en_req));

   // R9
   stop_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(running) |-> $past(frame_end) && !$past(en_req));

   // R9
   no_midframe_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      running && !frame_end |=> running);

   // R3
   frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      running && !frame_end |=> fcnt == $past(fcnt) + 1'b1);

   // R3
   frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> fcnt == '0);

   // R2
   line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      running && !frame_end && (hcnt == htot - 1'b1) |=> hcnt == '0);

   generate
      if (SHADOW) begin : g_hold
         // R10
         active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            running && !frame_end |=> $stable(period) && $stable(htot));
      end
   endgenerate
endmodule

bind frame_linear_vtg frame_linear_vtg_chk #(.HW(HW), .FW(FW), .SHADOW(SHADOW)) u_chk (
   .clk(clk), .rst_n(rst_n), .running(running), .en_req(en_req),
   .frame_end(frame_end), .hcnt(hcnt), .fcnt(fcnt), .htot(a_htot),
   .period(a_period)
);

// File: tb/tb_frame_linear_vtg.sv
module tb_frame_linear_vtg;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [3:0]    cfg_addr = '0;
   logic [31:0]   cfg_wdata = '0;
   logic [CW-1:0] pix_in = 24'h5A3C96;
   logic          pix_underflow = 1'b0;
   logic          hsync, vsync, disp_en;
   logic [CW-1:0] pix_out;

   int checks = 0;
   int fails = 0;

   // expected working set
   int e_h, e_hpw, e_p, e_vlen, e_hs, e_he, e_vs, e_ve, e_skew;
   int e_hpol, e_vpol, e_border, e_fill, e_rec;

   always #(CLK_PERIOD / 2) clk = ~clk;

   frame_linear_vtg dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .pix_in(pix_in), .pix_underflow(pix_underflow),
      .hsync(hsync), .vsync(vsync), .disp_en(disp_en), .pix_out(pix_out)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input int unsigned d);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_addr = a;
      cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic sync_frame(input string tag);
      bit prev = 1'b1;
      bit found = 1'b0;
      for (int n = 0; n < 4 * e_p + 100 && !found; n++) begin
         @(negedge clk);
         if ((vsync ^ e_vpol[0]) && !prev) found = 1'b1;
         prev = vsync ^ e_vpol[0];
      end
      check(found, "R3", {"vsync start found ", tag}, found, 1);
   endtask

   // Compares one frame pixel by pixel; optionally writes a register at
   // index wr_at and optionally expects the generator to stop afterwards.
   task automatic check_frame(input string tag, input int wr_at,
                              input logic [3:0] wa, input int unsigned wd,
                              input bit expect_stop);
      int bad_h = 0, bad_v = 0, bad_d = 0, bad_p = 0;
      int hc;
      bit xh, xv, xd;
      int xp;
      sync_frame(tag);
      for (int i = 0; i < e_p; i++) begin
         if (i > 0) @(negedge clk);
         if (i == wr_at + 1) cfg_we = 1'b0;
         hc = i % e_h;
         xh = (hc < e_hpw) ^ e_hpol[0];
         xv = (i < e_vlen) ^ e_vpol[0];
         xd = (hc >= e_hs) && (hc <= e_he) &&
              (i >= e_vs + e_skew) && (i <= e_ve + e_skew);
         xp = xd ? ((pix_underflow && e_rec != 0) ? e_fill : int'(pix_in)) : e_border;
         if (hsync !== xh) bad_h++;
         if (vsync !== xv) bad_v++;
         if (disp_en !== xd) bad_d++;
         if (int'(pix_out) != xp) bad_p++;
         if (i == wr_at) begin
            cfg_we = 1'b1;
            cfg_addr = wa;
            cfg_wdata = wd;
         end
      end
      @(negedge clk);
      cfg_we = 1'b0;
      check(bad_h == 0, "R2", {"hsync mismatches ", tag}, bad_h, 0);
      check(bad_v == 0, "R3", {"vsync mismatches ", tag}, bad_v, 0);
      check(bad_d == 0, "R4", {"disp_en mismatches ", tag}, bad_d, 0);
      check(bad_p == 0, "R6", {"pix_out mismatches ", tag}, bad_p, 0);
      if (expect_stop)
         check((vsync ^ e_vpol[0]) == 1'b0, "R9", {"no new frame ", tag}, vsync, e_vpol);
      else
         check((vsync ^ e_vpol[0]) == 1'b1, "R3", {"frame period ", tag}, vsync, !e_vpol);
   endtask

   task automatic check_idle(input string req, input string tag, input int cycles,
                             input int hlev, input int vlev);
      int bad = 0;
      for (int n = 0; n < cycles; n++) begin
         @(negedge clk);
         if (hsync !== hlev[0] || vsync !== vlev[0] || disp_en !== 1'b0 || pix_out !== '0)
            bad++;
      end
      check(bad == 0, req, {"idle outputs ", tag}, bad, 0);
   endtask

   task automatic test_reset();
      rst_n = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(hsync == 1'b0 && vsync == 1'b0, "R1", "sync low after reset", {hsync, vsync}, 0);
      check(disp_en == 1'b0, "R1", "disp_en low after reset", disp_en, 0);
      check(pix_out == '0, "R1", "pix_out zero after reset", pix_out, 0);
      check_idle("R1", "before enable", 30, 0, 0);
   endtask

   task automatic config_a();
      e_h = 10; e_hpw = 2; e_p = 60; e_vlen = 10; e_hs = 3; e_he = 8;
      e_vs = 20; e_ve = 49; e_skew = 0; e_hpol = 0; e_vpol = 0;
      e_border = 32'hAAAA00; e_fill = 32'hFF; e_rec = 1;
      wr(4'd1, (e_h << 16) | e_hpw);
      wr(4'd2, e_p);
      wr(4'd3, e_vlen);
      wr(4'd4, (e_he << 16) | e_hs);
      wr(4'd5, e_vs);
      wr(4'd6, e_ve);
      wr(4'd7, e_border);
      wr(4'd8, 32'h8000_0000 | e_fill);
      wr(4'd9, e_skew);
      wr(4'd10, 0);
      check_idle("R10", "writes while stopped", 10, 0, 0);
   endtask

   task automatic test_start_latency();
      wr(4'd0, 1);
      @(negedge clk);
      check(vsync == 1'b0, "R8", "vsync one clock after enable", vsync, 0);
      @(negedge clk);
      check(vsync == 1'b1, "R8", "vsync two clocks after enable", vsync, 1);
   endtask

   task automatic test_shadow_and_underflow();
      pix_underflow = 1'b0;
      // R10: mid-frame vsync length write must not change this frame
      check_frame("R10 frame A1", 3, 4'd3, 20, 1'b0);
      e_vlen = 20;
      // R7: fill with recovery on; clear recovery mid-frame
      pix_underflow = 1'b1;
      check_frame("R7 fill frame", 3, 4'd8, 32'h0000_00FF, 1'b0);
      e_rec = 0;
      // R7: recovery off passes pix_in; R9: clear enable mid-frame
      check_frame("R7 no-recovery frame", 5, 4'd0, 0, 1'b1);
      pix_underflow = 1'b0;
      check_idle("R9", "after stop A", 2 * e_p, 0, 0);
   endtask

   task automatic test_config_b();
      int p_old = e_p;
      wr(4'd1, (8 << 16) | 3);
      wr(4'd2, 40);
      wr(4'd3, 8);
      wr(4'd4, (6 << 16) | 2);
      wr(4'd5, 8);
      wr(4'd6, 31);
      wr(4'd9, 2);
      wr(4'd7, 32'h0000CC);
      wr(4'd10, 3);
      // R5 / R10: working polarity unchanged while stopped
      check_idle("R10", "polarity held while stopped", p_old, 0, 0);
      e_h = 8; e_hpw = 3; e_p = 40; e_vlen = 8; e_hs = 2; e_he = 6;
      e_vs = 8; e_ve = 31; e_skew = 2; e_hpol = 1; e_vpol = 1; e_border = 32'hCC;
      wr(4'd0, 1);
      check_frame("R5 R4 inverted skewed frame", e_p + 5, 4'd0, 0, 1'b0);
      check_frame("R9 B stop frame", 4, 4'd0, 0, 1'b1);
      check_idle("R5", "idle levels inverted", 2 * e_p, 1, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      test_reset();
      config_a();
      test_start_latency();
      test_shadow_and_underflow();
      test_config_b();
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule